// File: doc/BRIEF.md
# UART Receive Standby and Request Router

This block sits next to the bit-level receiver of a UART. The receiver reports each finished character, each detected line break and each idle-line period. From these events the block keeps a receive-full flag with its data holding register and an idle-line flag. It turns pending flags into an interrupt line or into one of two DMA request lines, chosen by configuration. Software or a DMA engine clears the receive-full flag by reading the data. It clears the idle flag with an acknowledge pulse.

The block also implements receiver standby. A standby request takes the receiver out of normal service. While it is in standby, characters are thrown away, no flag is set, and every request output is held low. Standby ends by itself in one of two ways, selected by a wake-method input. In idle wake, it ends on a qualified idle-line event. In address wake, it ends on a character whose top data bit is 1, and that character is delivered as normal receive data.

An idle event counts only after a character or a line break has arrived since the previous counted idle event. The `rx_active` output shows this armed condition. Software can use it to enter idle-wake standby only while the line is busy.

The standby state machine `uart_wake_fsm` has two states:
- **SB_RUN** goes to **SB_STANDBY** on a standby request.
- **SB_STANDBY** goes to **SB_RUN** on a wake event.

The line state machine `uart_idle_arm` has two states:
- **LN_QUIET** goes to **LN_ARMED** on a character or break.
- **LN_ARMED** goes to **LN_QUIET** on an idle event, unless a character or break arrives in the same cycle.

Top module: `uart_rx_wake_ctrl`

## Requirements
- R1: After reset, the outputs `standby`, `rx_full`, `idle_flag`, `rx_active`, `irq`, `dma_req_full` and `dma_req_idle` are 0, and `rx_data` is all zeros.
- R2: In SB_RUN, a pulse on `standby_set` makes `standby` read 1 from the next cycle on.
- R3: With `cfg_wake_addr`=0, an idle event while in standby and armed returns to SB_RUN in the next cycle and sets no idle flag. An idle event while not armed leaves standby on.
- R4: With `cfg_wake_addr`=1, a character with bit DATA_W-1 equal to 1 ends standby in the next cycle. That character is delivered: `rx_full`=1 and `rx_data` holds it. Characters with that bit 0, and idle events, leave standby on.
- R5: In standby, a character that does not end standby is discarded. `rx_full` does not rise and `rx_data` keeps its value.
- R6: In SB_RUN, a finished character sets `rx_full` and loads `rx_data` in the next cycle. A `data_rd` pulse clears `rx_full`. When a character and `data_rd` fall in the same cycle, `rx_full` stays 1 and holds the new character.
- R7: An idle event while armed and in SB_RUN sets `idle_flag` in the next cycle. `idle_ack` clears it, and a new set in the same cycle as `idle_ack` wins.
- R8: An idle event while not armed has no effect. A character or a break arms the line. `rx_active` is 1 exactly while the line is armed. Reset leaves the line not armed.
- R9: A pending `rx_full` with `cfg_full_en`=1 drives `irq` when `cfg_full_dma`=0 and `dma_req_full` when `cfg_full_dma`=1. With `cfg_full_en`=0 it drives neither.
- R10: A pending `idle_flag` with `cfg_idle_en`=1 drives `irq` when `cfg_idle_dma`=0 and `dma_req_idle` when `cfg_idle_dma`=1. With `cfg_idle_en`=0 it drives neither.
- R11: While `standby` is 1, `irq`, `dma_req_full` and `dma_req_idle` are 0, even when flags are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wake_addr | input | 1 | Wake method: 0 = idle line, 1 = address character |
| cfg_full_en | input | 1 | Receive-full request enable |
| cfg_full_dma | input | 1 | Receive-full request goes to DMA (1) or interrupt (0) |
| cfg_idle_en | input | 1 | Idle request enable |
| cfg_idle_dma | input | 1 | Idle request goes to DMA (1) or interrupt (0) |
| standby_set | input | 1 | Pulse: enter standby |
| ev_char_done | input | 1 | Pulse: a character finished |
| ev_char_data | input | DATA_W | Data of the finished character, address mark in the top bit |
| ev_break | input | 1 | Pulse: line break received |
| ev_idle | input | 1 | Pulse: idle line detected |
| data_rd | input | 1 | Pulse: data read or DMA acknowledge, clears receive-full |
| idle_ack | input | 1 | Pulse: clears idle flag |
| rx_data | output | DATA_W | Holding register for delivered data |
| rx_full | output | 1 | Receive-full flag |
| idle_flag | output | 1 | Idle-line flag |
| standby | output | 1 | Receiver is in standby |
| rx_active | output | 1 | Line armed: data seen since the last counted idle |
| irq | output | 1 | Interrupt request |
| dma_req_full | output | 1 | DMA request for received data |
| dma_req_idle | output | 1 | DMA request for idle line |

## Verification
The riskiest collisions are a flag being set and cleared in the same cycle, and a wake event arriving together with a character. The bench drives a character together with `data_rd`, and an armed idle together with `idle_ack`. It also drives an address character into standby while a standby request is still pulsing. Long random runs then mix all event pulses. A behavioural reference model applies the set-wins and wake-delivers rules independently, and every output is compared with it on each clock.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
    typedef enum logic {SB_RUN = 1'b0, SB_STANDBY = 1'b1} sb_state_t;
    typedef enum logic {LN_QUIET = 1'b0, LN_ARMED = 1'b1} line_state_t;
endpackage

// File: rtl/uart_wake_fsm.sv
module uart_wake_fsm
    import uart_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_set,
    input  logic wake_addr,
    input  logic idle_valid,
    input  logic addr_char,
    output logic standby,
    output logic wake
);
    sb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        wake    = 1'b0;
        unique case (state_q)
            SB_RUN: begin
                if (standby_set) state_d = SB_STANDBY;
            end
            SB_STANDBY: begin
                if (wake_addr ? addr_char : idle_valid) begin
                    wake    = 1'b1;
                    state_d = SB_RUN;
                end
            end
            default: state_d = SB_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SB_RUN;
        else        state_q <= state_d;
    end

    always_comb standby = (state_q == SB_STANDBY);

    assert_enter_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SB_RUN && standby_set) |=> standby);
    assert_idle_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !wake_addr && idle_valid) |=> !standby);
    assert_idle_no_wake_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && wake_addr && !addr_char) |=> standby);
endmodule

// File: rtl/uart_idle_arm.sv
module uart_idle_arm
    import uart_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_char_done,
    input  logic ev_break,
    input  logic ev_idle,
    output logic armed,
    output logic idle_valid
);
    line_state_t state_q, state_d;
    logic        line_data;

    always_comb begin
        line_data = ev_char_done | ev_break;
        state_d   = state_q;
        unique case (state_q)
            LN_QUIET: if (line_data) state_d = LN_ARMED;
            LN_ARMED: if (ev_idle && !line_data) state_d = LN_QUIET;
            default:  state_d = LN_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        armed      = (state_q == LN_ARMED);
        idle_valid = ev_idle & armed;
    end

    assert_quiet_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !ev_char_done && !ev_break) |=> !armed);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_rd,
    input  logic              idle_set,
    input  logic              idle_ack,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              idle_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full   <= 1'b0;
            rx_data   <= '0;
            idle_flag <= 1'b0;
        end else begin
            if (accept) begin
                rx_full <= 1'b1;
                rx_data <= data_in;
            end else if (data_rd) begin
                rx_full <= 1'b0;
            end
            if (idle_set)      idle_flag <= 1'b1;
            else if (idle_ack) idle_flag <= 1'b0;
        end
    end

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !accept) |=> !rx_full);
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && !idle_set) |=> !idle_flag);
endmodule

// File: rtl/uart_rx_wake_ctrl.sv
module uart_rx_wake_ctrl #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wake_addr,
    input  logic              cfg_full_en,
    input  logic              cfg_full_dma,
    input  logic              cfg_idle_en,
    input  logic              cfg_idle_dma,
    input  logic              standby_set,
    input  logic              ev_char_done,
    input  logic [DATA_W-1:0] ev_char_data,
    input  logic              ev_break,
    input  logic              ev_idle,
    input  logic              data_rd,
    input  logic              idle_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              idle_flag,
    output logic              standby,
    output logic              rx_active,
    output logic              irq,
    output logic              dma_req_full,
    output logic              dma_req_idle
);
    localparam int MARK_BIT = DATA_W - 1;
    localparam int NSRC     = 2;

    logic idle_valid, addr_char, wake, accept, idle_set;
    logic [NSRC-1:0] src_flag, src_en, src_dma, src_irq, src_dma_req;

    always_comb begin
        addr_char = ev_char_done & ev_char_data[MARK_BIT];
        accept    = ev_char_done & (!standby | (cfg_wake_addr & addr_char));
        idle_set  = idle_valid & !standby;
    end

    uart_wake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .standby_set(standby_set),
        .wake_addr(cfg_wake_addr), .idle_valid(idle_valid),
        .addr_char(addr_char), .standby(standby), .wake(wake)
    );

    uart_idle_arm u_arm (
        .clk(clk), .rst_n(rst_n), .ev_char_done(ev_char_done),
        .ev_break(ev_break), .ev_idle(ev_idle),
        .armed(rx_active), .idle_valid(idle_valid)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .accept(accept), .data_in(ev_char_data),
        .data_rd(data_rd), .idle_set(idle_set), .idle_ack(idle_ack),
        .rx_full(rx_full), .rx_data(rx_data), .idle_flag(idle_flag)
    );

    always_comb begin
        src_flag = {idle_flag, rx_full};
        src_en   = {cfg_idle_en, cfg_full_en};
        src_dma  = {cfg_idle_dma, cfg_full_dma};
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_route
        always_comb begin
            src_irq[i]     = src_flag[i] & src_en[i] & !src_dma[i] & !standby;
            src_dma_req[i] = src_flag[i] & src_en[i] &  src_dma[i] & !standby;
        end
    end

    always_comb begin
        irq          = |src_irq;
        dma_req_full = src_dma_req[0];
        dma_req_idle = src_dma_req[1];
    end

    assert_addr_wake_delivers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && cfg_wake_addr && addr_char) |=> (!standby && rx_full));
    assert_standby_discards_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !wake && !data_rd) |=> $stable(rx_data) && !$rose(rx_full));
    assert_unarmed_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_idle && !rx_active && !idle_ack) |=> $stable(idle_flag));
    assert_no_req_in_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !(irq || dma_req_full || dma_req_idle));
    assert_wake_drops_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !standby);
endmodule

// File: tb/tb_uart_rx_wake_ctrl.sv
module tb_uart_rx_wake_ctrl;
    localparam int DW = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wa = 0, fen = 0, fdma = 0, ien = 0, idma = 0;
    logic sset = 0, evc = 0, evb = 0, evi = 0, rd = 0, ack = 0;
    logic [DW-1:0] evd = '0;
    logic [DW-1:0] rx_data;
    logic rx_full, idle_flag, standby, rx_active, irq, dreq_f, dreq_i;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_sb, m_arm, m_full, m_idle;
    int m_data;

    uart_rx_wake_ctrl #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wake_addr(wa), .cfg_full_en(fen),
        .cfg_full_dma(fdma), .cfg_idle_en(ien), .cfg_idle_dma(idma),
        .standby_set(sset), .ev_char_done(evc), .ev_char_data(evd),
        .ev_break(evb), .ev_idle(evi), .data_rd(rd), .idle_ack(ack),
        .rx_data(rx_data), .rx_full(rx_full), .idle_flag(idle_flag),
        .standby(standby), .rx_active(rx_active), .irq(irq),
        .dma_req_full(dreq_f), .dma_req_idle(dreq_i)
    );

    always #2 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sb = 0; m_arm = 0; m_full = 0; m_idle = 0; m_data = 0;
        end else begin
            bit iv, wake, acc, iset;
            iv   = evi && m_arm;
            wake = m_sb && (wa ? (evc && evd[DW-1]) : iv);
            acc  = evc && (!m_sb || (wa && evd[DW-1]));
            iset = iv && !m_sb;
            m_arm = (evc || evb) ? 1 : (iv ? 0 : m_arm);
            m_sb  = m_sb ? !wake : sset;
            if (acc) begin m_full = 1; m_data = int'(evd); end
            else if (rd) m_full = 0;
            if (iset) m_idle = 1; else if (ack) m_idle = 0;
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        bit e_irq;
        e_irq = !m_sb && ((m_full && fen && !fdma) || (m_idle && ien && !idma));
        chk(standby, m_sb, "R2 standby");
        chk(rx_full, m_full, "R6 rx_full");
        chk(int'(rx_data), m_data, "R6 rx_data");
        chk(idle_flag, m_idle, "R7 idle_flag");
        chk(rx_active, m_arm, "R8 rx_active");
        chk(irq, e_irq, "R9 irq");
        chk(dreq_f, !m_sb && m_full && fen && fdma, "R9 dma_req_full");
        chk(dreq_i, !m_sb && m_idle && ien && idma, "R10 dma_req_idle");
    end

    // drive pulses for one cycle, then sample at the following falling edge
    task automatic cyc(input bit c, input int d, input bit b, input bit i,
                       input bit s, input bit r, input bit a);
        evc = c; evd = DW'(d); evb = b; evi = i; sset = s; rd = r; ack = a;
        @(negedge clk);
        evc = 0; evb = 0; evi = 0; sset = 0; rd = 0; ack = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(standby | rx_full | idle_flag | rx_active | irq | dreq_f | dreq_i, 0, "R1 flags");
        chk(int'(rx_data), 0, "R1 data");
        rst_n = 1;
        @(negedge clk);
        fen = 1; ien = 1;
        cyc(1, 'h055, 0, 0, 0, 0, 0);
        chk(rx_full, 1, "R6 set"); chk(irq, 1, "R9 irq");
        cyc(1, 'h0AA, 0, 0, 0, 1, 0);
        chk(rx_full, 1, "R6 collide"); chk(int'(rx_data), 'h0AA, "R6 collide data");
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(rx_full, 0, "R6 clear");
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(idle_flag, 1, "R7 set"); chk(rx_active, 0, "R8 disarm");
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(idle_flag, 0, "R8 unarmed idle ignored");
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk(rx_active, 1, "R8 break arms");
        idma = 1;
        cyc(0, 0, 0, 1, 0, 0, 1);
        chk(idle_flag, 1, "R7 set wins"); chk(dreq_i, 1, "R10 dma"); chk(irq, 0, "R10 no irq");
        fdma = 1;
        cyc(1, 'h011, 0, 0, 0, 0, 0);
        chk(dreq_f, 1, "R9 dma full");
        fen = 0;
        @(negedge clk); chk(dreq_f, 0, "R9 disabled");
        fen = 1; fdma = 0;
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk(standby, 1, "R2 enter"); chk(irq | dreq_i | dreq_f, 0, "R11 quiet");
        cyc(1, 'h033, 0, 0, 0, 1, 1);
        chk(int'(rx_data), 'h011, "R5 discard"); chk(standby, 1, "R5 stays");
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(standby, 0, "R3 idle wake"); chk(idle_flag, 0, "R3 no flag");
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk(standby, 1, "R3 enter unarmed");
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(standby, 1, "R3 unarmed idle keeps standby");
        wa = 1;
        cyc(1, 'h07F, 0, 0, 0, 0, 0);
        chk(standby, 1, "R4 no mark"); chk(rx_full, 0, "R5 no flag");
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(standby, 1, "R4 idle ignored");
        cyc(1, 'h1C3, 0, 0, 1, 0, 0);
        chk(standby, 0, "R4 wake"); chk(rx_full, 1, "R4 delivered");
        chk(int'(rx_data), 'h1C3, "R4 data");
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                wa = 1'($urandom); fen = 1'($urandom); fdma = 1'($urandom);
                ien = 1'($urandom); idma = 1'($urandom);
            end
            cyc(($urandom % 3) == 0, int'($urandom % 512), ($urandom % 11) == 0,
                ($urandom % 5) == 0, ($urandom % 13) == 0,
                ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule